// File: doc/BRIEF.md
# Banked Shader Register File with Indexed Source Addressing

This block holds the vector operands of a small shader core. Each entry is a four-lane vector of 32-bit lanes, and each lane carries one single-precision value. The core reads two source operands and writes one destination each cycle. A 7-bit register ID selects one of several banks. The same ID reaches a different physical bank depending on whether it is read or written. On the read side, low IDs select the input attributes, the next sixteen select the temporaries, and the upper part of the space selects the uniforms. On the write side, low IDs select the output bank.

Source 1 can be shifted by one of three index registers before it is decoded. Two of these registers are loaded together by a set-index command. The third is a loop counter that loop control starts and steps. Source 2 is only 5 bits wide, so it reaches inputs and temporaries only. Host-side ports load the uniforms and the attributes and read back the outputs. Instruction decode and arithmetic live outside this block.

Top module: `shader_regfile`

## Requirements
- R1: Every register is 128 bits (four 32-bit lanes). After reset, every register, the index registers, the loop counter and `illegal_write` are zero.
- R2: Source 1 decodes its effective ID as follows. 0x00–0x0F reads input attribute n. 0x10–0x1F reads temporary n−0x10. 0x20–0x7F reads uniform n−0x20. The read is combinational.
- R3: Source 2 is 5 bits wide. When bit 4 is 0 it reads input attribute `src2_id[3:0]`. When bit 4 is 1 it reads temporary `src2_id[3:0]`.
- R4: The source 1 effective ID is `src1_id` plus an offset, taken modulo 128. The offset is chosen by `src1_sel`: 0 adds nothing, 1 adds idx1, 2 adds idx2 and 3 adds the loop counter. For example, selector 2 with idx2 = 3 turns ID 0x28 into 0x2B.
- R5: A shader write with `dst_we` high is registered on the rising edge. IDs 0x00–0x0F write output n. IDs 0x10–0x1F write temporary n−0x10.
- R6: A shader write to an ID in 0x20–0x7F changes no register. `illegal_write` is high in the cycle after each such write, and low in the cycle after any other cycle.
- R7: `setidx_en` loads idx1 from `setidx_v1` and idx2 from `setidx_v2` on the same edge. Both hold their values otherwise.
- R8: `loop_start` loads the loop counter from `loop_init`. Otherwise `loop_step` adds `loop_incr`, modulo 256. If both are high, `loop_start` wins. With neither high, the counter keeps its value, including after the loop has ended.
- R9: A read of a register in the same cycle as a write to it returns the value from before the write.
- R10: `host_uni_we` writes uniform `host_uni_addr`, and writes to addresses 96 or above are ignored. `host_attr_we` writes input attribute `host_attr_addr`. `host_out_data` shows output register `host_out_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src1_id | input | 7 | Source 1 register ID |
| src1_sel | input | 2 | Source 1 offset selector |
| src1_data | output | 128 | Source 1 operand |
| src2_id | input | 5 | Source 2 register ID |
| src2_data | output | 128 | Source 2 operand |
| dst_we | input | 1 | Shader destination write enable |
| dst_id | input | 7 | Destination register ID |
| dst_data | input | 128 | Destination write data |
| illegal_write | output | 1 | Previous cycle wrote a read-only ID |
| setidx_en | input | 1 | Load idx1 and idx2 |
| setidx_v1 | input | 8 | New idx1 |
| setidx_v2 | input | 8 | New idx2 |
| loop_start | input | 1 | Load loop counter |
| loop_init | input | 8 | Loop counter start value |
| loop_step | input | 1 | Advance loop counter |
| loop_incr | input | 8 | Loop counter increment |
| host_uni_we | input | 1 | Host uniform write enable |
| host_uni_addr | input | 7 | Uniform index |
| host_uni_data | input | 128 | Uniform data |
| host_attr_we | input | 1 | Host attribute write enable |
| host_attr_addr | input | 4 | Attribute index |
| host_attr_data | input | 128 | Attribute data |
| host_out_addr | input | 4 | Output register to read |
| host_out_data | output | 128 | Output register contents |

## Verification
The assertions check three things on every cycle. The index registers and the loop counter hold their values when no command touches them. A zero selector leaves the source 1 ID untouched. The `illegal_write` flag follows each write to a read-only ID by exactly one cycle. The bench's scenarios are needed to show the rest: the bank selected by each read ID, wrap-around of the indexed address into a lower bank, old data returned on a read-during-write, and host writes to uniform indices 96 and above being dropped. A behavioural model compares all outputs on every clock, using both directed sequences and a long random run.

// File: rtl/shreg_pkg.sv
package shreg_pkg;
  localparam int LANES   = 4;
  localparam int LANE_W  = 32;
  localparam int VEC_W   = LANES * LANE_W;
  localparam int ID_W    = 7;
  localparam int N_IN    = 16;
  localparam int N_TMP   = 16;
  localparam int N_OUT   = 16;
  localparam int N_UNI   = (1 << ID_W) - N_IN - N_TMP;
  localparam int TMP_BASE = N_IN;
  localparam int UNI_BASE = N_IN + N_TMP;

  typedef logic [VEC_W-1:0] vec_t;
  typedef logic [ID_W-1:0]  rid_t;

  typedef enum logic [1:0] {BK_IN, BK_TMP, BK_UNI} rbank_e;

  // relative address: sum truncated to ID width (mod 128)
  function automatic rid_t rel_id(rid_t base, rid_t ofs);
    return rid_t'(base + ofs);
  endfunction

  function automatic rbank_e read_bank(rid_t id);
    if (int'(id) < TMP_BASE)      return BK_IN;
    else if (int'(id) < UNI_BASE) return BK_TMP;
    else                          return BK_UNI;
  endfunction
endpackage

// File: rtl/shreg_bank.sv
module shreg_bank #(
  parameter int DEPTH = 16,
  parameter int W     = 128,
  parameter int N_RD  = 1,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [AW-1:0]      wr_addr,
  input  logic [W-1:0]       wr_data,
  input  logic [N_RD*AW-1:0] rd_addr,
  output logic [N_RD*W-1:0]  rd_data
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we && (32'(wr_addr) < DEPTH)) begin
      mem[wr_addr] <= wr_data;
    end
  end

  for (genvar p = 0; p < N_RD; p++) begin : g_rd
    logic [AW-1:0] a;
    assign a = rd_addr[p*AW +: AW];
    assign rd_data[p*W +: W] = (32'(a) < DEPTH) ? mem[a] : '0;
  end
endmodule

// File: rtl/shreg_index.sv
module shreg_index #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             setidx_en,
  input  logic [IDX_W-1:0] setidx_v1,
  input  logic [IDX_W-1:0] setidx_v2,
  input  logic             loop_start,
  input  logic [IDX_W-1:0] loop_init,
  input  logic             loop_step,
  input  logic [IDX_W-1:0] loop_incr,
  output logic [IDX_W-1:0] idx1,
  output logic [IDX_W-1:0] idx2,
  output logic [IDX_W-1:0] lcnt
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx1 <= '0;
      idx2 <= '0;
    end else if (setidx_en) begin
      idx1 <= setidx_v1;
      idx2 <= setidx_v2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          lcnt <= '0;
    else if (loop_start) lcnt <= loop_init;
    else if (loop_step)  lcnt <= lcnt + loop_incr;
  end

  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !setidx_en |=> ($stable(idx1) && $stable(idx2))); // R7
  AST_LCNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop_start && !loop_step) |=> $stable(lcnt)); // R8
  AST_LCNT_START: assert property (@(posedge clk) disable iff (!rst_n)
    loop_start |=> (lcnt == $past(loop_init))); // R8
endmodule

// File: rtl/shader_regfile.sv
module shader_regfile
  import shreg_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ID_W-1:0]    src1_id,
  input  logic [1:0]         src1_sel,
  output logic [VEC_W-1:0]   src1_data,
  input  logic [4:0]         src2_id,
  output logic [VEC_W-1:0]   src2_data,
  input  logic               dst_we,
  input  logic [ID_W-1:0]    dst_id,
  input  logic [VEC_W-1:0]   dst_data,
  output logic               illegal_write,
  input  logic               setidx_en,
  input  logic [IDX_W-1:0]   setidx_v1,
  input  logic [IDX_W-1:0]   setidx_v2,
  input  logic               loop_start,
  input  logic [IDX_W-1:0]   loop_init,
  input  logic               loop_step,
  input  logic [IDX_W-1:0]   loop_incr,
  input  logic               host_uni_we,
  input  logic [ID_W-1:0]    host_uni_addr,
  input  logic [VEC_W-1:0]   host_uni_data,
  input  logic               host_attr_we,
  input  logic [3:0]         host_attr_addr,
  input  logic [VEC_W-1:0]   host_attr_data,
  input  logic [3:0]         host_out_addr,
  output logic [VEC_W-1:0]   host_out_data
);
  localparam int SAW = $clog2(N_IN);
  localparam int UAW = $clog2(N_UNI);

  // index registers
  logic [IDX_W-1:0] idx1, idx2, lcnt;
  shreg_index #(.IDX_W(IDX_W)) u_index (
    .clk, .rst_n, .setidx_en, .setidx_v1, .setidx_v2,
    .loop_start, .loop_init, .loop_step, .loop_incr,
    .idx1, .idx2, .lcnt
  );

  // source 1 effective address
  logic [IDX_W-1:0] ofs_sel;
  rid_t             src1_eff;
  rbank_e           src1_bank;
  always_comb begin
    case (src1_sel)
      2'd1:    ofs_sel = idx1;
      2'd2:    ofs_sel = idx2;
      2'd3:    ofs_sel = lcnt;
      default: ofs_sel = '0;
    endcase
  end
  assign src1_eff  = rel_id(src1_id, ofs_sel[ID_W-1:0]);
  assign src1_bank = read_bank(src1_eff);

  // destination decode (write-side bank map)
  logic wr_out, wr_tmp, wr_bad;
  assign wr_out = dst_we && (dst_id[ID_W-1:SAW] == '0);
  assign wr_tmp = dst_we && (int'(dst_id[ID_W-1:SAW]) == 1);
  assign wr_bad = dst_we && (int'(dst_id) >= UNI_BASE);

  always_ff @(posedge clk) begin
    if (!rst_n) illegal_write <= 1'b0;
    else        illegal_write <= wr_bad;
  end

  // banks
  logic [2*VEC_W-1:0] in_rd, tmp_rd;
  logic [VEC_W-1:0]   uni_rd;
  logic [UAW-1:0]     uni_ra;
  assign uni_ra = UAW'(src1_eff - rid_t'(UNI_BASE));

  shreg_bank #(.DEPTH(N_IN), .W(VEC_W), .N_RD(2)) u_in (
    .clk, .rst_n, .we(host_attr_we), .wr_addr(host_attr_addr), .wr_data(host_attr_data),
    .rd_addr({src2_id[SAW-1:0], src1_eff[SAW-1:0]}), .rd_data(in_rd)
  );
  shreg_bank #(.DEPTH(N_TMP), .W(VEC_W), .N_RD(2)) u_tmp (
    .clk, .rst_n, .we(wr_tmp), .wr_addr(dst_id[SAW-1:0]), .wr_data(dst_data),
    .rd_addr({src2_id[SAW-1:0], src1_eff[SAW-1:0]}), .rd_data(tmp_rd)
  );
  shreg_bank #(.DEPTH(N_UNI), .W(VEC_W), .N_RD(1)) u_uni (
    .clk, .rst_n, .we(host_uni_we), .wr_addr(host_uni_addr), .wr_data(host_uni_data),
    .rd_addr(uni_ra), .rd_data(uni_rd)
  );
  shreg_bank #(.DEPTH(N_OUT), .W(VEC_W), .N_RD(1)) u_out (
    .clk, .rst_n, .we(wr_out), .wr_addr(dst_id[SAW-1:0]), .wr_data(dst_data),
    .rd_addr(host_out_addr), .rd_data(host_out_data)
  );

  // read muxes
  always_comb begin
    case (src1_bank)
      BK_IN:   src1_data = in_rd[0 +: VEC_W];
      BK_TMP:  src1_data = tmp_rd[0 +: VEC_W];
      default: src1_data = uni_rd;
    endcase
  end
  assign src2_data = src2_id[SAW] ? tmp_rd[VEC_W +: VEC_W] : in_rd[VEC_W +: VEC_W];

  AST_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_out, wr_tmp, wr_bad})); // R5
  AST_NO_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    (src1_sel == 2'd0) |-> (src1_eff == src1_id)); // R4
  AST_ILLEGAL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_we && (int'(dst_id) >= UNI_BASE)) |=> illegal_write); // R6
  AST_ILLEGAL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    !(dst_we && (int'(dst_id) >= UNI_BASE)) |=> !illegal_write); // R6
endmodule

// File: tb/tb_shader_regfile.sv
`timescale 1ns/1ps
module tb_shader_regfile;
  localparam int VW = 128;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic [6:0]    src1_id;   logic [1:0] src1_sel;  logic [VW-1:0] src1_data;
  logic [4:0]    src2_id;   logic [VW-1:0] src2_data;
  logic          dst_we;    logic [6:0] dst_id;    logic [VW-1:0] dst_data;
  logic          illegal_write;
  logic          setidx_en; logic [7:0] setidx_v1, setidx_v2;
  logic          loop_start; logic [7:0] loop_init; logic loop_step; logic [7:0] loop_incr;
  logic          host_uni_we; logic [6:0] host_uni_addr; logic [VW-1:0] host_uni_data;
  logic          host_attr_we; logic [3:0] host_attr_addr; logic [VW-1:0] host_attr_data;
  logic [3:0]    host_out_addr; logic [VW-1:0] host_out_data;

  shader_regfile dut (.*);

  // reference model
  logic [VW-1:0] m_in [16];
  logic [VW-1:0] m_tmp[16];
  logic [VW-1:0] m_uni[96];
  logic [VW-1:0] m_out[16];
  int  r_i1, r_i2, r_lc;
  bit  r_ill;
  int  n_vec = 0, n_bad = 0;
  string tag = "";

  function automatic logic [VW-1:0] rv();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  function automatic logic [VW-1:0] exp_src1();
    int ofs, e;
    ofs = (src1_sel == 1) ? r_i1 : (src1_sel == 2) ? r_i2 : (src1_sel == 3) ? r_lc : 0;
    e = (int'(src1_id) + ofs) % 128;
    if (e < 16)      return m_in[e];
    else if (e < 32) return m_tmp[e - 16];
    else             return m_uni[e - 32];
  endfunction

  function automatic logic [VW-1:0] exp_src2();
    return (src2_id >= 16) ? m_tmp[src2_id - 16] : m_in[src2_id];
  endfunction

  task automatic cmp(string req, logic [VW-1:0] act, logic [VW-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s [%s] t=%0t got %h expected %h", req, tag, $time, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 16; i++) begin m_in[i] = '0; m_tmp[i] = '0; m_out[i] = '0; end
    for (int i = 0; i < 96; i++) m_uni[i] = '0;
    r_i1 = 0; r_i2 = 0; r_lc = 0; r_ill = 0;
  endtask

  task automatic idle();
    dst_we = 0; setidx_en = 0; loop_start = 0; loop_step = 0;
    host_uni_we = 0; host_attr_we = 0;
  endtask

  // one clock: compare before edge, update model at edge
  task automatic cyc();
    #1;
    cmp("R2/R4 src1", src1_data, exp_src1());
    cmp("R3 src2", src2_data, exp_src2());
    cmp("R10 host_out", host_out_data, m_out[host_out_addr]);
    cmp("R6 illegal_write", VW'(illegal_write), VW'(r_ill));
    @(posedge clk);
    if (host_attr_we) m_in[host_attr_addr] = host_attr_data;
    if (host_uni_we && host_uni_addr < 96) m_uni[host_uni_addr] = host_uni_data;
    r_ill = dst_we && dst_id >= 32;
    if (dst_we && dst_id < 16) m_out[dst_id] = dst_data;
    else if (dst_we && dst_id < 32) m_tmp[dst_id - 16] = dst_data;
    if (setidx_en) begin r_i1 = setidx_v1; r_i2 = setidx_v2; end
    if (loop_start) r_lc = loop_init;
    else if (loop_step) r_lc = (r_lc + loop_incr) % 256;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; idle();
    src1_id = 0; src1_sel = 0; src2_id = 0; dst_id = 0; dst_data = '0;
    setidx_v1 = 0; setidx_v2 = 0; loop_init = 0; loop_incr = 0;
    host_uni_addr = 0; host_uni_data = '0; host_attr_addr = 0; host_attr_data = '0;
    host_out_addr = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1: everything zero after reset, sweep IDs through all banks
    tag = "R1 reset";
    for (int i = 0; i < 128; i += 9) begin
      src1_id = 7'(i); src2_id = 5'(i); host_out_addr = 4'(i); src1_sel = 2'(i);
      cmp("R1 src1 zero", src1_data, '0);
      cyc();
    end
    src1_sel = 0;

    // R10: host loads; uniform index >= 96 dropped
    tag = "R10 host load";
    for (int i = 0; i < 16; i++) begin
      host_attr_we = 1; host_attr_addr = 4'(i); host_attr_data = rv(); cyc();
    end
    idle();
    for (int i = 0; i < 128; i++) begin
      host_uni_we = 1; host_uni_addr = 7'(i); host_uni_data = rv(); cyc();
    end
    idle();
    // R2: read back every ID through source 1
    tag = "R2 decode";
    for (int i = 0; i < 128; i++) begin src1_id = 7'(i); src2_id = 5'(i); cyc(); end

    // R5: fill temporaries and outputs
    tag = "R5 writes";
    for (int i = 0; i < 32; i++) begin
      dst_we = 1; dst_id = 7'(i); dst_data = rv(); host_out_addr = 4'(i); cyc();
    end
    idle();
    for (int i = 0; i < 32; i++) begin src2_id = 5'(i); host_out_addr = 4'(i); cyc(); end

    // R7/R4: set-index then 0x28 with idx2=3 reads 0x2B
    tag = "R7 setidx";
    setidx_en = 1; setidx_v1 = 8'd5; setidx_v2 = 8'd3; cyc(); idle();
    src1_id = 7'h28; src1_sel = 2'd2;
    #1 cmp("R4 0x28+idx2", src1_data, m_uni[7'h2B - 32]);
    cyc();
    // R4 wrap: 0x20 + 0x70 -> 0x10 (temporary 0)
    tag = "R4 wrap";
    setidx_en = 1; setidx_v1 = 8'h70; setidx_v2 = 8'hF1; cyc(); idle();
    src1_id = 7'h20; src1_sel = 2'd1;
    #1 cmp("R4 wrap to temp", src1_data, m_tmp[0]);
    cyc();
    src1_sel = 2'd2; cyc();

    // R8: loop start, steps, hold after end, start beats step
    tag = "R8 loop";
    loop_start = 1; loop_init = 8'd2; cyc(); idle();
    src1_id = 7'h30; src1_sel = 2'd3;
    for (int i = 0; i < 4; i++) begin loop_step = 1; loop_incr = 8'd1; cyc(); end
    idle(); repeat (3) cyc();
    loop_start = 1; loop_step = 1; loop_init = 8'd7; loop_incr = 8'd9; cyc(); idle();
    cyc();
    loop_step = 1; loop_incr = 8'hFE; repeat (5) cyc(); idle(); cyc();

    // R9: read and write same temporary in one cycle returns old value
    tag = "R9 rd-during-wr";
    src1_sel = 0; src1_id = 7'h13; src2_id = 5'h13;
    dst_we = 1; dst_id = 7'h13; dst_data = rv();
    #1 cmp("R9 src1 old", src1_data, m_tmp[3]);
    cyc(); idle(); cyc();

    // R6: back-to-back illegal writes, then legal one
    tag = "R6 illegal";
    src1_id = 7'h45;
    dst_we = 1; dst_id = 7'h45; dst_data = rv(); cyc();
    dst_id = 7'h7F; dst_data = rv(); cyc();
    dst_id = 7'h02; cyc(); idle(); cyc(); cyc();

    // random traffic
    tag = "random";
    for (int n = 0; n < 3000; n++) begin
      src1_id = 7'($urandom); src1_sel = 2'($urandom); src2_id = 5'($urandom);
      dst_we = ($urandom % 2) == 0; dst_id = 7'($urandom); dst_data = rv();
      setidx_en = ($urandom % 8) == 0; setidx_v1 = 8'($urandom); setidx_v2 = 8'($urandom);
      loop_start = ($urandom % 16) == 0; loop_init = 8'($urandom);
      loop_step = ($urandom % 4) == 0; loop_incr = 8'($urandom);
      host_uni_we = ($urandom % 4) == 0; host_uni_addr = 7'($urandom); host_uni_data = rv();
      host_attr_we = ($urandom % 4) == 0; host_attr_addr = 4'($urandom); host_attr_data = rv();
      host_out_addr = 4'($urandom);
      cyc();
    end
    idle();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule